// File: doc/BRIEF.md
# Programmable Processor Watchdog with Output Steering

This block supervises a processor by expecting it to touch a single 8-bit control register often enough. The register sets a timeout as a 5-bit multiplier times one of four resolutions. A steering bit decides what happens when the processor fails to access the register in time. In one mode a held interrupt request is raised. In the other mode a timed active-low reset pulse is produced, and the block also wipes its own setting and asks the neighbouring frequency-test control to clear.

Time is measured with a one-cycle enable that arrives every 1/16 second (`tick_i`). All timing is counted in those units. A power-up pulse returns the block to its disabled state. Every pin is a plain level or single-cycle strobe. No data stream crosses the boundary, so there is no valid/ready handshake and no back-pressure.

Top module: `wdt_steer_top`

## Requirements
- R1: After `rst_n` deasserts or `pwr_up_i` pulses, the register reads 00h, `wd_flag_o` and `irq_o` are 0, and `rst_pulse_n_o` is 1.
- R2: The register layout is: bit 7 is the steering bit, bits 6..2 are the multiplier M, and bits 1..0 are the resolution code R. The codes are 0 = 1/16 s, 1 = 1/4 s, 2 = 1 s and 3 = 4 s. The timeout is M·4^R ticks, counted from the last restart. The timeout event happens in the cycle of the M·4^R-th tick.
- R3: A register read (`reg_rd_i`) or a register write (`reg_wr_i`) restarts the count from zero.
- R4: When M = 0, the watchdog is disabled and no timeout occurs, whatever R is. This includes 00h, the value after power-up.
- R5: Every timeout sets `wd_flag_o`. A flags read (`flag_rd_i`) clears it, unless a timeout happens in the same cycle; in that case the flag stays set.
- R6: With the steering bit at 0, a timeout raises `irq_o`. It stays high until a flags read, a register read or a register write.
- R7: With the steering bit at 1, a timeout drives `rst_pulse_n_o` low for exactly PULSE_LEN cycles, starting the cycle after the timeout. It leaves `irq_o` at 0.
- R8: A steering-bit-1 timeout clears the register to 00h, which disables further timeouts. It also pulses `ftest_clr_o` high for one cycle, aligned with the start of the reset pulse.
- R9: A register access in the same cycle as the expiring tick suppresses that timeout and restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | 1/16-second timebase enable, one cycle wide |
| pwr_up_i | input | 1 | Power-up pulse; clears the register, flags and pulse |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rd_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 8 | Current register value |
| flag_rd_i | input | 1 | Flags register read strobe |
| wd_flag_o | output | 1 | Watchdog flag |
| irq_o | output | 1 | Interrupt request, active high |
| rst_pulse_n_o | output | 1 | Active-low reset pulse |
| ftest_clr_o | output | 1 | One-cycle request to clear the frequency-test bit |

## Verification
Two events can land in the same cycle:
- **Access on the expiring tick.** The bench asserts a register read on the very tick that would end the count. It then expects no timeout, followed by a full fresh period before the interrupt appears.
- **Flags read on the expiring tick.** The bench asserts a flags read in the same cycle as an expiring tick. It then expects the flag to remain set.

In addition, a sweep over all four resolutions and several multipliers checks that the timeout lands on exactly the M·4^R-th tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WDT_MULT_W = 5;
  localparam int WDT_RES_W  = 2;
  localparam int WDT_REG_W  = 1 + WDT_MULT_W + WDT_RES_W;
  // largest scale is 4^(2^RES_W - 1): shift of 2*(2^RES_W - 1) bits
  localparam int WDT_MAX_SHIFT = 2 * ((1 << WDT_RES_W) - 1);
  localparam int WDT_CNT_W     = WDT_MULT_W + WDT_MAX_SHIFT;

  typedef struct packed {
    logic                  steer;
    logic [WDT_MULT_W-1:0] mult;
    logic [WDT_RES_W-1:0]  res;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pwr_up_i,
  input  logic     wr_i,
  input  wdt_cfg_t wdata_i,
  input  logic     self_clr_i,
  output wdt_cfg_t cfg_o
);
  wdt_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cfg_q <= '0;
    else if (pwr_up_i)   cfg_q <= '0;
    else if (wr_i)       cfg_q <= wdata_i;
    else if (self_clr_i) cfg_q <= '0;
  end

  assign cfg_o = cfg_q;

  p_self_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (self_clr_i && !wr_i) |=> (cfg_q == '0));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick_i,
  input  logic     restart_i,
  input  wdt_cfg_t cfg_i,
  output logic     expire_o
);
  localparam int SHW = $clog2(WDT_MAX_SHIFT + 1);

  logic [WDT_CNT_W-1:0] cnt_q;
  logic [WDT_CNT_W-1:0] limit;
  logic [SHW-1:0]       shamt;
  logic                 enabled;

  always_comb begin
    shamt   = SHW'({cfg_i.res, 1'b0});
    limit   = WDT_CNT_W'(cfg_i.mult) << shamt;
    enabled = (cfg_i.mult != '0);
  end

  assign expire_o = enabled && tick_i && !restart_i &&
                    (cnt_q == limit - WDT_CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (restart_i || !enabled) cnt_q <= '0;
    else if (expire_o)            cnt_q <= '0;
    else if (tick_i)              cnt_q <= cnt_q + WDT_CNT_W'(1);
  end

  p_cnt_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    enabled |-> (cnt_q < limit));
  p_access_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_outputs.sv
module wdt_outputs #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_up_i,
  input  logic expire_i,
  input  logic steer_i,
  input  logic flag_rd_i,
  input  logic reg_acc_i,
  output logic wd_flag_o,
  output logic irq_o,
  output logic rst_pulse_n_o,
  output logic ftest_clr_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          wf_q, irq_q, ft_q;
  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wf_q <= 1'b0; irq_q <= 1'b0; ft_q <= 1'b0; pcnt_q <= '0;
    end else if (pwr_up_i) begin
      wf_q <= 1'b0; irq_q <= 1'b0; ft_q <= 1'b0; pcnt_q <= '0;
    end else begin
      ft_q <= expire_i && steer_i;
      if (expire_i)       wf_q <= 1'b1;
      else if (flag_rd_i) wf_q <= 1'b0;
      if (expire_i && !steer_i)           irq_q <= 1'b1;
      else if (flag_rd_i || reg_acc_i)    irq_q <= 1'b0;
      if (expire_i && steer_i)   pcnt_q <= PW'(PULSE_LEN);
      else if (pcnt_q != '0)     pcnt_q <= pcnt_q - PW'(1);
    end
  end

  assign wd_flag_o     = wf_q;
  assign irq_o         = irq_q;
  assign rst_pulse_n_o = (pcnt_q == '0);
  assign ftest_clr_o   = ft_q;

  p_flag_on_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && !pwr_up_i) |=> wf_q);
  p_irq_needs_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> wf_q);
  p_reset_steer_no_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_i && steer_i && !pwr_up_i && !$past(irq_q)) |=> !irq_q);
endmodule

// File: rtl/wdt_steer_top.sv
module wdt_steer_top
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 pwr_up_i,
  input  logic                 reg_wr_i,
  input  logic [WDT_REG_W-1:0] reg_wdata_i,
  input  logic                 reg_rd_i,
  output logic [WDT_REG_W-1:0] reg_rdata_o,
  input  logic                 flag_rd_i,
  output logic                 wd_flag_o,
  output logic                 irq_o,
  output logic                 rst_pulse_n_o,
  output logic                 ftest_clr_o
);
  wdt_cfg_t cfg;
  logic     expire;
  logic     reg_acc;

  assign reg_acc = reg_wr_i || reg_rd_i;

  wdt_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_up_i   (pwr_up_i),
    .wr_i       (reg_wr_i),
    .wdata_i    (wdt_cfg_t'(reg_wdata_i)),
    .self_clr_i (expire && cfg.steer),
    .cfg_o      (cfg)
  );

  wdt_timer u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .restart_i (reg_acc || pwr_up_i),
    .cfg_i     (cfg),
    .expire_o  (expire)
  );

  wdt_outputs #(.PULSE_LEN(PULSE_LEN)) u_out (
    .clk           (clk),
    .rst_n         (rst_n),
    .pwr_up_i      (pwr_up_i),
    .expire_i      (expire),
    .steer_i       (cfg.steer),
    .flag_rd_i     (flag_rd_i),
    .reg_acc_i     (reg_acc),
    .wd_flag_o     (wd_flag_o),
    .irq_o         (irq_o),
    .rst_pulse_n_o (rst_pulse_n_o),
    .ftest_clr_o   (ftest_clr_o)
  );

  assign reg_rdata_o = WDT_REG_W'(cfg);

  p_disabled_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mult == '0) |-> !expire);
  p_access_blocks_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_acc |=> !$rose(wd_flag_o));
endmodule

// File: tb/tb_wdt_steer_top.sv
module tb_wdt_steer_top;
  localparam int PL = 12;
  logic clk = 0, rst_n = 0;
  logic tick = 0, pwr = 0, wr = 0, rd = 0, frd = 0;
  logic [7:0] wdata = 0, rdata;
  logic wf, irq, rpn, ftc;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  wdt_steer_top #(.PULSE_LEN(PL)) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .pwr_up_i(pwr),
    .reg_wr_i(wr), .reg_wdata_i(wdata), .reg_rd_i(rd), .reg_rdata_o(rdata),
    .flag_rd_i(frd), .wd_flag_o(wf), .irq_o(irq),
    .rst_pulse_n_o(rpn), .ftest_clr_o(ftc));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; @(negedge clk); tick = 0;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic wreg(input logic [7:0] v);
    wr = 1; wdata = v; @(negedge clk); wr = 0;
  endtask
  task automatic rreg();  rd = 1;  @(negedge clk); rd = 0;  endtask
  task automatic rflag(); frd = 1; @(negedge clk); frd = 0; endtask

  initial begin
    #200000;
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int mults[4] = '{1, 2, 5, 31};
    int lows;
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata, 0); chk("R1 flag", wf, 0);
    chk("R1 irq", irq, 0);     chk("R1 pulse", rpn, 1);
    // R4 disabled after reset and with M=0, R=3
    ticks(70);
    chk("R4 no timeout at 00h", wf, 0);
    wreg(8'h03); ticks(70);
    chk("R4 no timeout M=0 R=3", wf, 0);
    // R2 sweep, steering 0, R6 irq
    for (int r = 0; r < 4; r++) begin
      for (int mi = 0; mi < 4; mi++) begin
        int lim;
        lim = mults[mi] * (1 << (2 * r));
        wreg(8'((mults[mi] << 2) | r));
        ticks(lim - 1);
        chk("R2 early", irq, 0);
        ticks(1);
        chk("R2 at limit irq", irq, 1);
        chk("R5 flag set", wf, 1);
        rflag();
        chk("R5 flag cleared", wf, 0);
        chk("R6 irq cleared by flag read", irq, 0);
        wreg(8'h00);
      end
    end
    // R3 restart by read and write; R6 clear by reg read/write
    wreg(8'h0C);
    ticks(2); rreg(); ticks(2);
    chk("R3 read restarts", irq, 0);
    ticks(1); chk("R3 timeout after read", irq, 1);
    rreg(); chk("R6 irq cleared by reg read", irq, 0);
    chk("R6 flag still set", wf, 1);
    rflag();
    ticks(2); wreg(8'h0C); ticks(2);
    chk("R3 write restarts", irq, 0);
    ticks(1); chk("R3 timeout after write", irq, 1);
    wreg(8'h0C); chk("R6 irq cleared by reg write", irq, 0);
    rflag();
    // R9 access on expiring tick
    ticks(2);
    tick = 1; rd = 1; @(negedge clk); tick = 0; rd = 0;
    repeat (3) @(negedge clk);
    chk("R9 access suppresses timeout", wf, 0);
    ticks(2); chk("R9 fresh period", wf, 0);
    ticks(1); chk("R9 timeout after fresh period", irq, 1);
    rflag(); wreg(8'h04);
    // R5 flags read on expiring tick
    tick = 1; frd = 1; @(negedge clk); tick = 0; frd = 0;
    chk("R5 set wins over read", wf, 1);
    rflag(); wreg(8'h00); rflag();
    // R7 / R8 reset steering, M=2 R=0
    wreg(8'h88);
    ticks(1);
    chk("R7 no pulse early", rpn, 1);
    tick = 1; @(negedge clk); tick = 0;
    chk("R7 pulse started", rpn, 0);
    chk("R8 ftest clear pulse", ftc, 1);
    chk("R8 register cleared", rdata, 0);
    chk("R7 no irq", irq, 0);
    chk("R5 flag on reset timeout", wf, 1);
    lows = 0;
    while (rpn == 0 && lows < 100) begin lows++; @(negedge clk); end
    chk("R7 pulse length", lows, PL);
    chk("R8 ftest single cycle", ftc, 0);
    rflag(); ticks(10);
    chk("R8 disabled after self clear", wf, 0);
    // R1 power-up pulse
    wreg(8'h04); ticks(1);
    chk("R1 pre power-up flag", wf, 1);
    pwr = 1; @(negedge clk); pwr = 0;
    chk("R1 pwr clears reg", rdata, 0);
    chk("R1 pwr clears flag", wf, 0);
    chk("R1 pwr clears irq", irq, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule